// File: doc/BRIEF.md
# Voice PCM Serial Port

This block moves 14-bit linear voice samples between a codec core and a baseband controller over a framed serial link. A frame lasts 256 bit clocks, which is 8 kHz at a 2.048 MHz bit clock. Each frame carries one transmit word, taken from the converter side, and one receive word, handed to the converter side. The controller is the far end of the serial link.

A direction input picks the timing source. In master mode the port divides its system clock down to make the bit clock and frame sync, and it ignores the external clock and sync pins. In slave mode it oversamples an external bit clock and sync through synchronizers and holds its own clock and sync outputs low. Everything inside runs on the system clock, and bit-clock edges are handled as one-cycle strobes.

A loopback control sends the most recently received word back out as the transmit word in place of the converter sample.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `fsync_o`, `sdout` and `dac_valid` are 0 and `dac_word` is zero. No bit clock is generated until reset is released.
- R2: With `slave_sel` = 0, `bclk_o` first rises on the HALF_DIV-th system clock edge after reset release. After that it toggles every HALF_DIV edges, giving a 50:50 duty cycle.
- R3: With `slave_sel` = 0, `fsync_o` rises together with `bclk_o`, stays high for exactly one bit-clock period, and repeats every 256 rising edges. The first sync pulse comes with the first rising edge.
- R4: With `slave_sel` = 1, `bclk_o` and `fsync_o` are held at 0 and timing comes from `bclk_i` and `fsync_i`. With `slave_sel` = 0, `bclk_i` and `fsync_i` have no effect.
- R5: A frame starts on a bit-clock falling edge where the sampled sync is 1 and was 0 on the previous falling edge. In slave mode a pulse covering a single falling edge (half a period) starts a frame, and a pulse held across two falling edges starts only one frame.
- R6: The transmit word is latched at the frame start, from `adc_word` when `loop_en` = 0. The 14 bit-clock rising edges after the frame start drive bits 13 down to 0 on `sdout`, most significant first. Every other rising edge drives 0. In master mode `sdout` changes only in the cycle where `bclk_o` rises.
- R7: `sdin` is sampled on the 14 falling edges after the frame start, most significant bit first, and the other slots are ignored. After the 14th sample, `dac_word` is updated and `dac_valid` pulses high for exactly one system clock. In master mode that pulse comes in the same cycle that `bclk_o` falls.
- R8: When `loop_en` = 1 at a frame start, the transmit word is the last completed receive word in place of `adc_word`. That word is zero if none has been received since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, HALF_DIV x 2 x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_sel | input | 1 | 0: generate clock and sync, 1: accept external ones |
| loop_en | input | 1 | Send last received word in place of the converter sample |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fsync_i | input | 1 | External frame sync (slave mode) |
| sdin | input | 1 | Serial receive data |
| adc_word | input | WORD_W | Transmit sample from the converter side |
| bclk_o | output | 1 | Generated bit clock (master mode), else 0 |
| fsync_o | output | 1 | Generated frame sync (master mode), else 0 |
| sdout | output | 1 | Serial transmit data |
| dac_word | output | WORD_W | Last received sample |
| dac_valid | output | 1 | One-cycle strobe when a new `dac_word` is available |

## Verification
In master mode, `bclk_o`, `fsync_o` and `sdout` all change on the same system edge, and `dac_valid` rises on the edge where `bclk_o` falls. The bench therefore compares them, on the falling system clock after that edge, with a model that counts cycles since reset. In slave mode, each external edge passes through two synchronizer stages and one register, so results appear three system cycles late. The bench reads `sdout` only at the end of each eight-cycle half period, and counts the `dac_valid` pulses in each frame. Loopback words and mid-frame changes to `adc_word` are timed away from the frame start, so the word that is latched is never ambiguous.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // One-cycle strobes marking bit-clock edges, plus the sync level seen at that edge
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
    } bit_evt_t;

    // Counter width for a modulus, never less than one bit
    function automatic int cnt_w(input int modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
    import pcm_pkg::*;
#(
    parameter int HALF_DIV   = 6,
    parameter int FRAME_BITS = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    output logic     bclk,
    output logic     fsync,
    output bit_evt_t evt
);

    localparam int CW = cnt_w(HALF_DIV);
    localparam int BW = cnt_w(FRAME_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
        logic [BW-1:0] bitn;
        logic          fs;
    } gen_t;

    localparam gen_t GEN_IDLE = '{cnt: '0, bclk: 1'b0, bitn: BIT_LAST, fs: 1'b0};

    gen_t          q, d;
    logic          half_done;
    logic [BW-1:0] bit_nx;

    always_comb begin
        d         = q;
        half_done = (q.cnt == CNT_LAST);
        bit_nx    = (q.bitn == BIT_LAST) ? '0 : q.bitn + BW'(1);
        if (!en) begin
            d = GEN_IDLE;
        end else begin
            d.cnt = half_done ? '0 : q.cnt + CW'(1);
            if (half_done) begin
                d.bclk = ~q.bclk;
                if (!q.bclk) begin
                    // rising edge: advance the slot number, sync marks slot zero
                    d.bitn = bit_nx;
                    d.fs   = (bit_nx == '0);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= GEN_IDLE;
        end else begin
            q <= d;
        end
    end

    assign bclk     = q.bclk;
    assign fsync    = q.fs;
    assign evt.rise = en & half_done & ~q.bclk;
    assign evt.fall = en & half_done & q.bclk;
    assign evt.fs   = q.fs;

endmodule

// File: rtl/pcm_slave_front.sv
module pcm_slave_front
    import pcm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     bclk_in,
    input  logic     fs_in,
    input  logic     sd_in,
    output bit_evt_t evt,
    output logic     sd_bit
);

    localparam int LANES   = 3;
    localparam int L_BCLK  = 0;
    localparam int L_FS    = 1;
    localparam int L_SD    = 2;

    typedef struct packed {
        logic [LANES-1:0][STAGES-1:0] pipe;
        logic                         bclk_prev;
    } front_t;

    front_t           q, d;
    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;

    assign raw = {sd_in, fs_in, bclk_in};

    // every lane goes through the same depth, so all three stay aligned in time
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign synced[g] = q.pipe[g][STAGES-1];
        end
    endgenerate

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                d.pipe[l] = (q.pipe[l] << 1) | STAGES'(raw[l]);
            end
            d.bclk_prev = synced[L_BCLK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign evt.rise = en & synced[L_BCLK] & ~q.bclk_prev;
    assign evt.fall = en & ~synced[L_BCLK] & q.bclk_prev;
    assign evt.fs   = synced[L_FS];
    assign sd_bit   = synced[L_SD];

endmodule

// File: rtl/pcm_frame.sv
module pcm_frame
    import pcm_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bit_evt_t          evt,
    input  logic              sd_bit,
    input  logic              loop_en,
    input  logic [WORD_W-1:0] adc_word,
    output logic              sdout,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid
);

    localparam int LW = $clog2(WORD_W + 1);
    localparam logic [LW-1:0] LEFT_FULL = LW'(WORD_W);
    localparam logic [LW-1:0] LEFT_ONE  = LW'(1);

    typedef struct packed {
        logic              fs_prev;
        logic [WORD_W-1:0] tx_sh;
        logic [LW-1:0]     tx_left;
        logic              sdout;
        logic [WORD_W-1:0] rx_sh;
        logic [LW-1:0]     rx_left;
        logic [WORD_W-1:0] rx_word;
        logic              rx_valid;
    } frm_t;

    frm_t              q, d;
    logic              frame_start;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        d           = q;
        d.rx_valid  = 1'b0;
        frame_start = evt.fall & evt.fs & ~q.fs_prev;
        rx_next     = {q.rx_sh[WORD_W-2:0], sd_bit};

        if (evt.fall) begin
            d.fs_prev = evt.fs;
            if (frame_start) begin
                d.tx_sh   = loop_en ? q.rx_word : adc_word;
                d.tx_left = LEFT_FULL;
                d.rx_left = LEFT_FULL;
            end else if (q.rx_left != '0) begin
                d.rx_sh   = rx_next;
                d.rx_left = q.rx_left - LEFT_ONE;
                if (q.rx_left == LEFT_ONE) begin
                    d.rx_word  = rx_next;
                    d.rx_valid = 1'b1;
                end
            end
        end

        if (evt.rise) begin
            if (q.tx_left != '0) begin
                d.sdout   = q.tx_sh[WORD_W-1];
                d.tx_sh   = q.tx_sh << 1;
                d.tx_left = q.tx_left - LEFT_ONE;
            end else begin
                d.sdout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdout     = q.sdout;
    assign dac_word  = q.rx_word;
    assign dac_valid = q.rx_valid;

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_pkg::*;
#(
    parameter int HALF_DIV    = 6,
    parameter int FRAME_BITS  = 256,
    parameter int WORD_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_sel,
    input  logic              loop_en,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              sdin,
    input  logic [WORD_W-1:0] adc_word,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              sdout,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid
);

    bit_evt_t evt_m, evt_s, evt;
    logic     bclk_m, fsync_m;
    logic     sd_slave, sd_bit;

    pcm_clkgen #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (~slave_sel),
        .bclk  (bclk_m),
        .fsync (fsync_m),
        .evt   (evt_m)
    );

    pcm_slave_front #(
        .STAGES (SYNC_STAGES)
    ) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (slave_sel),
        .bclk_in (bclk_i),
        .fs_in   (fsync_i),
        .sd_in   (sdin),
        .evt     (evt_s),
        .sd_bit  (sd_slave)
    );

    assign evt    = slave_sel ? evt_s : evt_m;
    assign sd_bit = slave_sel ? sd_slave : sdin;

    pcm_frame #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .sd_bit    (sd_bit),
        .loop_en   (loop_en),
        .adc_word  (adc_word),
        .sdout     (sdout),
        .dac_word  (dac_word),
        .dac_valid (dac_valid)
    );

    assign bclk_o  = bclk_m & ~slave_sel;
    assign fsync_o = fsync_m & ~slave_sel;

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
    parameter int HALF_DIV = 6
) (
    input logic clk,
    input logic rst_n,
    input logic slave_sel,
    input logic bclk_o,
    input logic fsync_o,
    input logic sdout,
    input logic dac_valid
);

    logic [31:0] run_q;
    logic        prev_b_q;
    logic        seen_q;

    // length of the current steady stretch of bclk_o, counted in samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            prev_b_q <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            prev_b_q <= bclk_o;
            if (slave_sel) begin
                run_q  <= '0;
                seen_q <= 1'b0;
            end else if (bclk_o != prev_b_q) begin
                run_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                run_q <= run_q + 32'd1;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!bclk_o && !fsync_o && !sdout && !dac_valid));

    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !slave_sel && (bclk_o != $past(bclk_o))) |-> (run_q == 32'(HALF_DIV - 1)));

    a_r3_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_sel && !$past(slave_sel) && (fsync_o != $past(fsync_o)))
            |-> (bclk_o && !$past(bclk_o)));

    a_r6_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_sel && !$past(slave_sel) && (sdout != $past(sdout)))
            |-> (bclk_o && !$past(bclk_o)));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

endmodule

bind pcm_serial_port pcm_serial_port_chk #(
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_sel (slave_sel),
    .bclk_o    (bclk_o),
    .fsync_o   (fsync_o),
    .sdout     (sdout),
    .dac_valid (dac_valid)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;

    localparam int H  = 6;
    localparam int FB = 256;
    localparam int W  = 14;
    localparam int SH = 8;   // slave half period in system clocks

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slave_sel = 1'b0;
    logic         loop_en = 1'b0;
    logic         bclk_i = 1'b0;
    logic         fsync_i = 1'b0;
    logic         sdin = 1'b0;
    logic [W-1:0] adc_word = 14'h2001;
    logic         bclk_o, fsync_o, sdout, dac_valid;
    logic [W-1:0] dac_word;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pcm_serial_port #(
        .HALF_DIV (H), .FRAME_BITS (FB), .WORD_W (W), .SYNC_STAGES (2)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .slave_sel (slave_sel), .loop_en (loop_en),
        .bclk_i (bclk_i), .fsync_i (fsync_i), .sdin (sdin), .adc_word (adc_word),
        .bclk_o (bclk_o), .fsync_o (fsync_o), .sdout (sdout),
        .dac_word (dac_word), .dac_valid (dac_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rx_pat(input int i);
        return W'((i * 5413 + 1) ^ 14'h2AAA);
    endfunction

    function automatic logic [W-1:0] tx_pat(input int i);
        return W'((i * 3301) ^ 14'h1555);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic drive_master_pins(input bit sd_val, input bit new_adc, input logic [W-1:0] adc_val);
        sdin    = sd_val;
        bclk_i  = 1'($urandom);
        fsync_i = 1'($urandom);
        if (new_adc) adc_word = adc_val;
    endtask

    // ---------------- reference model, compared on every clock ----------------
    int           e = 0;
    int           pb, pfs, slot, fall_n, fr_idx = 0;
    bit           in_frame;
    logic [W-1:0] exp_tx, bword, last_rx;
    int           sv_cnt;
    logic [W-1:0] sv_exp;
    int           qh, rr;
    bit           eb, efs, rise_m, fall_m, exp_v, exp_sd;

    always @(posedge clk) begin
        if (!rst_n || slave_sel) e <= 0;
        else                     e <= e + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1: everything quiet while reset is held
            check(bclk_o == 1'b0,    "R1 bclk_o", bclk_o, 0);
            check(fsync_o == 1'b0,   "R1 fsync_o", fsync_o, 0);
            check(sdout == 1'b0,     "R1 sdout", sdout, 0);
            check(dac_valid == 1'b0, "R1 dac_valid", dac_valid, 0);
            check(dac_word == '0,    "R1 dac_word", dac_word, 0);
            pb = 0; pfs = 0; in_frame = 0; last_rx = '0;
        end else if (!slave_sel) begin
            qh  = e / H;
            eb  = (qh % 2) == 1;
            rr  = (qh + 1) / 2;
            efs = (rr >= 1) && (((rr - 1) % FB) == 0);
            check(bclk_o == eb,   "R2 bclk_o", bclk_o, eb);
            check(fsync_o == efs, "R3 fsync_o", fsync_o, efs);
            rise_m = eb && (pb == 0);
            fall_m = !eb && (pb == 1);
            exp_v  = 1'b0;
            if (fall_m) begin
                if (efs && (pfs == 0)) begin
                    // R5/R8: frame start latches the transmit word
                    exp_tx   = loop_en ? last_rx : adc_word;
                    bword    = rx_pat(fr_idx);
                    fr_idx++;
                    in_frame = 1;
                    slot     = 0;
                    fall_n   = 0;
                end else if (in_frame) begin
                    fall_n++;
                    if (fall_n == W) exp_v = 1'b1;
                end
                pfs = efs;
            end
            check(dac_valid == exp_v, "R7 dac_valid", dac_valid, exp_v);
            if (exp_v) begin
                check(dac_word == bword, "R7 dac_word", dac_word, bword);
                last_rx = bword;
            end
            if (rise_m) begin
                exp_sd = (in_frame && slot < W) ? exp_tx[W-1-slot] : 1'b0;
                check(sdout == exp_sd, loop_en ? "R8 sdout" : "R6 sdout", sdout, exp_sd);
                drive_master_pins((in_frame && slot < W) ? bword[W-1-slot] : 1'($urandom),
                                  in_frame && slot == 20, tx_pat(fr_idx));
                if (in_frame) slot++;
            end else begin
                // R4: external clock and sync pins wiggle without effect in master mode
                drive_master_pins(sdin, 1'b0, adc_word);
            end
            pb = eb;
        end else begin
            check(bclk_o == 1'b0 && fsync_o == 1'b0, "R4 outputs low in slave", {bclk_o, fsync_o}, 0);
            if (dac_valid) begin
                sv_cnt++;
                check(dac_word == sv_exp, "R7 slave dac_word", dac_word, sv_exp);
            end
        end
    end

    // fs_mode 0: half-period pulse, 1: one period, 2: held across two falling edges
    task automatic slave_frame(input logic [W-1:0] rxw, input logic [W-1:0] txw,
                               input int fs_mode, input int nbits);
        adc_word = txw;
        sv_exp   = rxw;
        sv_cnt   = 0;
        bclk_i = 1'b1; fsync_i = 1'b1; sdin = 1'b0;
        step(SH);
        bclk_i = 1'b0;
        if (fs_mode == 0) begin
            step(2); fsync_i = 1'b0; step(SH - 2);
        end else begin
            step(SH);
        end
        for (int s = 0; s < nbits; s++) begin
            bclk_i  = 1'b1;
            fsync_i = (fs_mode == 2) && (s == 0);
            sdin    = (s < W) ? rxw[W-1-s] : 1'($urandom);
            step(SH);
            check(sdout == ((s < W) ? txw[W-1-s] : 1'b0), "R6 slave sdout",
                  sdout, (s < W) ? txw[W-1-s] : 0);
            bclk_i = 1'b0;
            step(SH);
        end
        check(sv_cnt == 1, "R5 one frame per sync pulse", sv_cnt, 1);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2 * FB * 2 * H + FB * H);   // mid third frame
        loop_en = 1'b1;                  // R8: fourth frame returns third frame's word
        step(FB * 2 * H);
        loop_en = 1'b0;
        step(FB * 2 * H);
        rst_n = 1'b0;                    // R1: reset in the middle of a frame
        step(20);
        rst_n = 1'b1;
        step(600);
        rst_n = 1'b0;
        slave_sel = 1'b1;
        bclk_i = 1'b0; fsync_i = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(4);
        slave_frame(14'h1ACE, 14'h3FFF, 0, 20);
        slave_frame(14'h0001, 14'h2000, 1, 20);
        slave_frame(14'h3FFF, 14'h0A5F, 2, 20);
        step(20);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule